// File: doc/BRIEF.md
# Dual-Port Doorbell Mailbox

This block lets two processors ring doorbells at each other through shared status words. It has three channels, and each channel has a receive word and a transmit word, each 32 bits wide. A sender raises bits by writing a set register. The receiver reads the word and acknowledges by writing the same bits to a clear register. Each word drives an interrupt line for as long as it holds any bit. A sender treats its last doorbell as taken once the word it rang reads zero again.

Two APB-style slave ports see the same register map, one for each processor. Every access carries a non-secure qualifier. The third channel answers only to secure accesses. A non-secure access to that channel gets an error response, reads as zero and has no effect on a write. A small bank of identification registers reports a fixed 24-bit peripheral code. The ports never insert wait states.

Top module: `mbx_doorbell`

## Requirements
- R1: Channel windows start at 0x000 (channel 0), 0x020 (channel 1) and 0x200 (channel 2). The transmit word of a channel is at its window base plus 0x100. Inside each window, the word's status register is at +0x00, its set register at +0x08 and its clear register at +0x10.
- R2: A write to a set register ORs the written bits into the matching word and leaves bits that are already set unchanged.
- R3: A write to a clear register drops the written bits from the word. Writing back the value read from status empties the word.
- R4: A status read returns the current word. Set and clear registers read as zero. Unmapped offsets read as zero, and writes to them change no word.
- R5: rx_irq[c] is high exactly while the receive word of channel c is nonzero, and tx_irq[c] is high exactly while the transmit word of channel c is nonzero. A word that has been cleared reads zero.
- R6: An access with pnonsec=1 to any channel 2 register (0x200-0x21F or 0x300-0x31F) returns pslverr=1 and prdata=0, and a write does not change the word. A secure access to the same registers works and returns pslverr=0.
- R7: Identification registers at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return the bytes 0x98, 0xB0, 0x1B and 0x00 in bits 7:0, which together give 0x1BB098.
- R8: When the two ports write the set and clear registers of the same word in one cycle, the clear is applied first and the set second, so the set bits survive. Two sets to the same word in one cycle OR together.
- R9: After reset, all six words are zero and every interrupt line is low.
- R10: A write takes effect at the clock edge that ends its access phase (psel=1, penable=1). pready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | NPORT | Per-port select |
| penable | input | NPORT | Per-port access phase |
| pwrite | input | NPORT | Per-port write (1) or read (0) |
| pnonsec | input | NPORT | Per-port non-secure qualifier |
| paddr | input | NPORT*AW | Per-port byte address |
| pwdata | input | NPORT*DW | Per-port write data |
| prdata | output | NPORT*DW | Per-port read data |
| pready | output | NPORT | Per-port ready, always 1 |
| pslverr | output | NPORT | Per-port error response |
| rx_irq | output | 3 | Receive-word-nonzero interrupt for each channel |
| tx_irq | output | 3 | Transmit-word-nonzero interrupt for each channel |

## Verification
The two functions that can land in the same cycle are a set and a clear aimed at one status word, each arriving through a different port. The bench preloads a word and then drives both ports through their access phases together. One port clears the preloaded bits while the other sets an overlapping pattern. The following status read must show exactly the set pattern. A second case has both ports set disjoint bits of one word, and the result must be their OR.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NCH     = 3;
  localparam int NDIR    = 2;
  localparam int NW      = NCH * NDIR;
  localparam int SEC_CH  = 2;
  localparam logic [4:0] OFS_STAT = 5'h00;
  localparam logic [4:0] OFS_SET  = 5'h08;
  localparam logic [4:0] OFS_CLR  = 5'h10;
  localparam logic [31:0] TX_STEP = 32'h100;
  localparam logic [31:0] ID_BASE = 32'hFE0;

  // word index w: channel = w % NCH, direction = w / NCH (0 receive, 1 transmit)
  function automatic logic [31:0] win_base(input int w);
    logic [31:0] b;
    case (w % NCH)
      0:       b = 32'h000;
      1:       b = 32'h020;
      default: b = 32'h200;
    endcase
    if (w >= NCH) b = b + TX_STEP;
    return b;
  endfunction
endpackage

// File: rtl/mbx_word.sv
module mbx_word #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_nxt;
  logic          q_en;

  always_comb begin
    q_en  = (|set_i) | (|clr_i);
    q_nxt = (q_o & ~clr_i) | set_i;   // clear first, then set
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (q_en) q_o <= q_nxt;
  end

  AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R8
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !((|set_i) || (|clr_i)) |=> $stable(q_o)); // R4
endmodule

// File: rtl/mbx_apb_decode.sv
module mbx_apb_decode
  import mbx_pkg::*;
#(
  parameter int          AW  = 12,
  parameter int          DW  = 32,
  parameter logic [23:0] PID = 24'h1BB098
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic             pnonsec,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  input  logic [NW*DW-1:0] stat_flat,
  output logic [NW*DW-1:0] set_flat,
  output logic [NW*DW-1:0] clr_flat,
  output logic [DW-1:0]    prdata,
  output logic             pslverr
);
  localparam logic [31:0] ID_WORD = {8'h00, PID};

  logic acc;
  assign acc = psel & penable;

  always_comb begin
    set_flat = '0;
    clr_flat = '0;
    prdata   = '0;
    pslverr  = 1'b0;
    for (int w = 0; w < NW; w++) begin
      logic [31:0] b;
      b = win_base(w);
      if (acc && (paddr[AW-1:5] == b[AW-1:5])) begin
        if (((w % NCH) == SEC_CH) && pnonsec) begin
          pslverr = 1'b1;
        end else begin
          case (paddr[4:0])
            OFS_STAT: if (!pwrite) prdata = stat_flat[w*DW +: DW];
            OFS_SET:  if (pwrite)  set_flat[w*DW +: DW] = pwdata;
            OFS_CLR:  if (pwrite)  clr_flat[w*DW +: DW] = pwdata;
            default:  ;
          endcase
        end
      end
    end
    if (acc && !pwrite && (paddr[AW-1:4] == ID_BASE[AW-1:4]) && (paddr[1:0] == 2'b00))
      prdata = DW'(ID_WORD[paddr[3:2]*8 +: 8]);
  end

  AST_ERR_ONLY_NONSEC: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (pnonsec && psel && penable)); // R6
  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (prdata == '0)); // R6
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int          NPORT = 2,
  parameter int          AW    = 12,
  parameter int          DW    = 32,
  parameter logic [23:0] PID   = 24'h1BB098
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    psel,
  input  logic [NPORT-1:0]    penable,
  input  logic [NPORT-1:0]    pwrite,
  input  logic [NPORT-1:0]    pnonsec,
  input  logic [NPORT*AW-1:0] paddr,
  input  logic [NPORT*DW-1:0] pwdata,
  output logic [NPORT*DW-1:0] prdata,
  output logic [NPORT-1:0]    pready,
  output logic [NPORT-1:0]    pslverr,
  output logic [NCH-1:0]      rx_irq,
  output logic [NCH-1:0]      tx_irq
);
  localparam int WB = NW * DW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [WB-1:0] stat_flat;
  logic [WB-1:0] set_p [NPORT];
  logic [WB-1:0] clr_p [NPORT];
  logic [WB-1:0] set_all, clr_all;

  assign pready = '1;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_apb_decode #(.AW(AW), .DW(DW), .PID(PID)) i_dec (
      .clk       (clk),
      .rst_n     (rst_sn),
      .psel      (psel[p]),
      .penable   (penable[p]),
      .pwrite    (pwrite[p]),
      .pnonsec   (pnonsec[p]),
      .paddr     (paddr[p*AW +: AW]),
      .pwdata    (pwdata[p*DW +: DW]),
      .stat_flat (stat_flat),
      .set_flat  (set_p[p]),
      .clr_flat  (clr_p[p]),
      .prdata    (prdata[p*DW +: DW]),
      .pslverr   (pslverr[p])
    );
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < NPORT; p++) begin
      set_all = set_all | set_p[p];
      clr_all = clr_all | clr_p[p];
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    mbx_word #(.DW(DW)) i_word (
      .clk   (clk),
      .rst_n (rst_sn),
      .set_i (set_all[w*DW +: DW]),
      .clr_i (clr_all[w*DW +: DW]),
      .q_o   (stat_flat[w*DW +: DW])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    assign rx_irq[c] = |stat_flat[c*DW +: DW];
    assign tx_irq[c] = |stat_flat[(c+NCH)*DW +: DW];

    AST_RX_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_sn)
      $rose(rx_irq[c]) |-> $past(|set_all[c*DW +: DW])); // R5
    AST_TX_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_sn)
      $fell(tx_irq[c]) |-> $past(|clr_all[(c+NCH)*DW +: DW])); // R5
  end
endmodule

// File: tb/test_mbx_doorbell.sv
module test_mbx_doorbell;
  localparam int NP = 2;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [NP-1:0]     psel, penable, pwrite, pnonsec;
  logic [NP*AW-1:0]  paddr;
  logic [NP*DW-1:0]  pwdata;
  logic [NP*DW-1:0]  prdata;
  logic [NP-1:0]     pready, pslverr;
  logic [2:0]        rx_irq, tx_irq;

  int n_run  = 0;
  int n_fail = 0;

  mbx_doorbell #(.NPORT(NP), .AW(AW), .DW(DW)) i_mbx_doorbell (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pnonsec(pnonsec), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  function automatic logic [11:0] base_of(input int w);
    logic [11:0] b;
    b = ((w % 3) == 0) ? 12'h000 : ((w % 3) == 1) ? 12'h020 : 12'h200;
    return (w >= 3) ? b + 12'h100 : b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb(input int p, input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input bit ns, output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel[p] = 1'b1; penable[p] = 1'b0; pwrite[p] = wr; pnonsec[p] = ns;
    paddr[p*AW +: AW] = a; pwdata[p*DW +: DW] = d;
    @(negedge clk);
    penable[p] = 1'b1;
    #1;
    rd = prdata[p*DW +: DW]; err = pslverr[p];
    @(negedge clk);
    psel[p] = 1'b0; penable[p] = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    apb(0, 1'b1, a, d, 1'b0, r, e);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    logic e;
    apb(1, 1'b0, a, 32'h0, 1'b0, v, e);
  endtask

  task automatic dual_wr(input logic [11:0] a0, input logic [31:0] d0,
                         input logic [11:0] a1, input logic [31:0] d1);
    @(negedge clk);
    psel = 2'b11; penable = 2'b00; pwrite = 2'b11; pnonsec = 2'b00;
    paddr = {a1, a0}; pwdata = {d1, d0};
    @(negedge clk);
    penable = 2'b11;
    @(negedge clk);
    psel = 2'b00; penable = 2'b00;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R9 rx_irq after reset", {29'h0, rx_irq}, 32'h0);
    chk("R9 tx_irq after reset", {29'h0, tx_irq}, 32'h0);
    for (int w = 0; w < 6; w++) begin
      rd(base_of(w), v);
      chk("R9 word zero after reset", v, 32'h0);
    end
  endtask

  task automatic t_map;
    logic [31:0] v;
    for (int w = 0; w < 6; w++) begin
      wr(base_of(w) + 12'h008, 32'h11 * (w + 1));
      for (int k = 0; k < 6; k++) begin
        rd(base_of(k), v);
        chk("R1 window map", v, (k == w) ? 32'h11 * (w + 1) : 32'h0);
      end
      wr(base_of(w) + 12'h010, 32'h11 * (w + 1));
    end
  endtask

  task automatic t_set_clear;
    logic [31:0] v;
    wr(12'h028, 32'h0000_000F);
    wr(12'h028, 32'h0000_00F0);
    rd(12'h020, v);
    chk("R2 set ORs bits", v, 32'h0000_00FF);
    wr(12'h030, 32'h0000_000F);
    rd(12'h020, v);
    chk("R3 clear drops bits", v, 32'h0000_00F0);
    wr(12'h030, v);
    rd(12'h020, v);
    chk("R3 write-back empties word", v, 32'h0);
  endtask

  task automatic t_reads;
    logic [31:0] v;
    wr(12'h008, 32'hCAFE_0001);
    rd(12'h008, v);
    chk("R4 set reg reads zero", v, 32'h0);
    rd(12'h010, v);
    chk("R4 clear reg reads zero", v, 32'h0);
    rd(12'h004, v);
    chk("R4 unmapped reads zero", v, 32'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h000, v);
    chk("R4 unmapped write ignored", v, 32'hCAFE_0001);
    wr(12'h010, 32'hCAFE_0001);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(12'h028, 32'h8000_0000);
    chk("R5 rx_irq channel 1", {29'h0, rx_irq}, 32'h2);
    wr(12'h108, 32'h1);
    chk("R5 tx_irq channel 0", {29'h0, tx_irq}, 32'h1);
    wr(12'h110, 32'h1);
    rd(12'h100, v);
    chk("R5 delivered tx word reads zero", v, 32'h0);
    chk("R5 tx_irq low after clear", {29'h0, tx_irq}, 32'h0);
    wr(12'h030, 32'h8000_0000);
    chk("R5 rx_irq low after clear", {29'h0, rx_irq}, 32'h0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    psel[0] = 1'b1; penable[0] = 1'b0; pwrite[0] = 1'b1; pnonsec[0] = 1'b0;
    paddr[0 +: AW] = 12'h008; pwdata[0 +: DW] = 32'h4;
    @(negedge clk);
    penable[0] = 1'b1;
    #1;
    chk("R10 pready high", {30'h0, pready}, 32'h3);
    chk("R10 no effect before edge", {29'h0, rx_irq}, 32'h0);
    @(negedge clk);
    psel[0] = 1'b0; penable[0] = 1'b0;
    chk("R10 effect after edge", {29'h0, rx_irq}, 32'h1);
    wr(12'h010, 32'h4);
  endtask

  task automatic t_secure;
    logic [31:0] v; logic e;
    apb(0, 1'b1, 12'h208, 32'h5, 1'b1, v, e);
    chk("R6 nonsec write errors", {31'h0, e}, 32'h1);
    rd(12'h200, v);
    chk("R6 nonsec write ignored", v, 32'h0);
    apb(0, 1'b1, 12'h208, 32'h5, 1'b0, v, e);
    chk("R6 secure write no error", {31'h0, e}, 32'h0);
    chk("R6 secure write rings channel 2", {29'h0, rx_irq}, 32'h4);
    apb(1, 1'b0, 12'h200, 32'h0, 1'b1, v, e);
    chk("R6 nonsec read zero", v, 32'h0);
    chk("R6 nonsec read errors", {31'h0, e}, 32'h1);
    apb(1, 1'b1, 12'h210, 32'h5, 1'b1, v, e);
    rd(12'h200, v);
    chk("R6 nonsec clear ignored", v, 32'h5);
    apb(1, 1'b1, 12'h308, 32'h1, 1'b1, v, e);
    chk("R6 nonsec tx window errors", {31'h0, e}, 32'h1);
    chk("R6 nonsec tx write ignored", {29'h0, tx_irq}, 32'h0);
    apb(1, 1'b0, 12'h020, 32'h0, 1'b1, v, e);
    chk("R6 nonsec other channel no error", {31'h0, e}, 32'h0);
    wr(12'h210, 32'h5);
  endtask

  task automatic t_id;
    logic [31:0] v;
    rd(12'hFE0, v); chk("R7 id byte 0", v, 32'h98);
    rd(12'hFE4, v); chk("R7 id byte 1", v, 32'hB0);
    rd(12'hFE8, v); chk("R7 id byte 2", v, 32'h1B);
    rd(12'hFEC, v); chk("R7 id byte 3", v, 32'h00);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(12'h008, 32'h0000_00FF);
    dual_wr(12'h010, 32'h0000_00FF, 12'h008, 32'h0000_000F);
    rd(12'h000, v);
    chk("R8 set survives same-cycle clear", v, 32'h0000_000F);
    dual_wr(12'h128, 32'h0001_0000, 12'h128, 32'h0000_0002);
    rd(12'h120, v);
    chk("R8 two sets OR", v, 32'h0001_0002);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h130, 32'hFFFF_FFFF);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; psel = '0; penable = '0; pwrite = '0; pnonsec = '0;
    paddr = '0; pwdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_set_clear();
    t_reads();
    t_irq();
    t_timing();
    t_secure();
    t_id();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule